// File: doc/BRIEF.md
# Divided-Clock Countdown Timer

This block is a per-core countdown timer that raises a vectored interrupt request when it expires. Software programs it through a small register port. A divide register selects a power-of-two prescale of the input clock. A start-value register loads the countdown and starts it. A read-only register reports how many prescaled ticks remain. An event-entry register holds the interrupt vector, a suppression bit and a repeat bit.

Each write to the start-value register drops any countdown in progress and begins a new one of N prescaled ticks. When the count runs out, the block emits a one-cycle request carrying the programmed vector, unless the entry suppresses it. In repeat mode the count then reloads from the start value; otherwise it stops at zero. Acceptance and prioritisation of the request happen outside this block.

Top module: `tick_timer`

## Requirements
- R1: The register select codes are: 0 for the event entry, 1 for the start value, 2 for the remaining count and 3 for divide. The divide register keeps bits 3:0 of the written data and reads them back. The divisor is D = 2^((s+1) mod 8), where s = {bit3, bit1, bit0}. Bit 2 has no effect on D. So s=7 gives D=1, and s=0..6 gives D=2..128.
- R2: A write of N>0 to the start value (select 1) starts a countdown. Let edge k be the clock edge that captures this write. The request `irq` is high for the single cycle that follows edge k+N*D.
- R3: While the timer runs, a read of select 2 returns the remaining input clocks divided by D, rounded up. It reads N straight after the start and drops by one every D clocks. A write to select 2 has no effect.
- R4: A read of select 2 returns 0 when the timer is not running. This holds after reset, after a one-shot expiry and after a write of 0 to the start value.
- R5: A write to the start value while a countdown is running restarts the countdown from the new value.
- R6: Event-entry bits 12 and 14 are read-only. Writes to them are ignored and they keep their value, which is 0 from reset. All other written entry bits read back as written.
- R7: When entry bit 16 is set, it suppresses `irq`, but the count still decrements.
- R8: When entry bit 17 is set, the count reloads from the start value on expiry, giving a request every N*D clocks. When bit 17 is clear, the count stops at 0.
- R9: `irq` is a one-cycle pulse. While `irq` is high, `irq_vector` equals entry bits 7:0.
- R10: After reset, the entry reads 0x00010000 (suppressed), the other registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | DATA_W | Read data (combinational from rd_sel) |
| irq | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector that goes with irq |

## Verification
Register reads are combinational, so the bench samples a read one nanosecond after it sets the select, midway between edges. A start write is captured at edge k. The request shows up in the cycle after edge k+N*D, so the bench counts falling edges from the write and expects the first high `irq` on exactly the N*D-th one. The remaining count changes on the edge that completes each group of D clocks, so the bench samples it after a known number of edges.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic [1:0] {
      SEL_ENTRY = 2'd0,
      SEL_START = 2'd1,
      SEL_LEFT  = 2'd2,
      SEL_DIV   = 2'd3
   } reg_sel_e;

   localparam int ENT_RO_LO    = 12;
   localparam int ENT_RO_HI    = 14;
   localparam int ENT_SUPPRESS = 16;
   localparam int ENT_REPEAT   = 17;
   localparam int ENT_MIN_W    = 18;
   localparam int SHIFT_W      = 3;
   localparam int N_SHIFTS     = 1 << SHIFT_W;
   localparam int PHASE_W      = N_SHIFTS;
endpackage

// File: rtl/tt_regfile.sv
module tt_regfile
   import tick_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] entry_q,
   output logic [CNT_W-1:0]  start_q,
   output logic [3:0]        div_q,
   output logic              load
);
   localparam logic [DATA_W-1:0] RO_MASK =
      (DATA_W'(1) << ENT_RO_LO) | (DATA_W'(1) << ENT_RO_HI);
   localparam logic [DATA_W-1:0] ENTRY_RST = DATA_W'(1) << ENT_SUPPRESS;

   logic wr_entry, wr_start, wr_div;

   assign wr_entry = wr_en && (wr_sel == SEL_ENTRY);
   assign wr_start = wr_en && (wr_sel == SEL_START);
   assign wr_div   = wr_en && (wr_sel == SEL_DIV);
   assign load     = wr_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_q <= ENTRY_RST;
         start_q <= '0;
         div_q   <= '0;
      end else begin
         if (wr_entry) entry_q <= (wr_data & ~RO_MASK) | (entry_q & RO_MASK);
         if (wr_start) start_q <= wr_data[CNT_W-1:0];
         if (wr_div)   div_q   <= wr_data[3:0];
      end
   end

   p_ro_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_entry |=> ((entry_q & RO_MASK) == ($past(entry_q) & RO_MASK)));
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler
   import tick_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] div_cfg,
   input  logic       load,
   input  logic       running,
   output logic       step
);
   logic [PHASE_W-1:0] lut [N_SHIFTS];
   logic [SHIFT_W-1:0] shift;
   logic [PHASE_W-1:0] divisor;
   logic [PHASE_W-1:0] phase_q;

   for (genvar g = 0; g < N_SHIFTS; g++) begin : g_div_lut
      assign lut[g] = PHASE_W'(1) << ((g + 1) % N_SHIFTS);
   end

   assign shift   = {div_cfg[3], div_cfg[1:0]};
   assign divisor = lut[shift];
   assign step    = running && (phase_q == PHASE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (load)    phase_q <= divisor;
      else if (step)    phase_q <= divisor;
      else if (running) phase_q <= phase_q - PHASE_W'(1);
   end

   p_phase_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (phase_q != '0));
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  logic             repeat_en,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             suppress,
   input  logic [VEC_W-1:0] vector,
   output logic [CNT_W-1:0] cnt_q,
   output logic             running,
   output logic             irq_q,
   output logic [VEC_W-1:0] vec_q
);
   logic last;

   assign running = (cnt_q != '0);
   assign last    = !load && step && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
         vec_q <= '0;
      end else begin
         if (load)      cnt_q <= load_val;
         else if (last) cnt_q <= repeat_en ? reload_val : '0;
         else if (step) cnt_q <= cnt_q - CNT_W'(1);
         irq_q <= last && !suppress;
         if (last) vec_q <= vector;
      end
   end

   p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && (cnt_q > CNT_W'(1))) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(cnt_q));
   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(cnt_q) == CNT_W'(1)));
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> !$past(suppress));
   p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !$past(repeat_en)) |-> (cnt_q == '0));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic [VEC_W-1:0]  irq_vector
);
   if (DATA_W < ENT_MIN_W) begin : g_bad_data_w
      $error("DATA_W must hold the event entry bits");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (VEC_W < 1 || VEC_W > ENT_RO_LO) begin : g_bad_vec_w
      $error("VEC_W must fit below the read-only entry bits");
   end

   logic [DATA_W-1:0] entry_q;
   logic [CNT_W-1:0]  start_q;
   logic [3:0]        div_q;
   logic              load;
   logic              step;
   logic              running;
   logic [CNT_W-1:0]  cnt_q;

   tt_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .entry_q(entry_q), .start_q(start_q), .div_q(div_q), .load(load)
   );

   tt_prescaler pre_i (
      .clk(clk), .rst_n(rst_n), .div_cfg(div_q), .load(load),
      .running(running), .step(step)
   );

   tt_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data[CNT_W-1:0]),
      .step(step), .repeat_en(entry_q[ENT_REPEAT]), .reload_val(start_q),
      .suppress(entry_q[ENT_SUPPRESS]), .vector(entry_q[VEC_W-1:0]),
      .cnt_q(cnt_q), .running(running), .irq_q(irq), .vec_q(irq_vector)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_ENTRY: rd_data = entry_q;
         SEL_START: rd_data = DATA_W'(start_q);
         SEL_LEFT:  rd_data = DATA_W'(cnt_q);
         default:   rd_data = DATA_W'(div_q);
      endcase
   end
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [31:0] wr_data;
   logic [1:0]  rd_sel;
   logic [31:0] rd_data;
   logic        irq;
   logic [7:0]  irq_vector;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .irq_vector(irq_vector)
   );

   localparam int NROW = 7;
   localparam logic [3:0] T_CONF [NROW] = '{4'hB, 4'h0, 4'h4, 4'h1, 4'hF, 4'h3, 4'hA};
   localparam int         T_N    [NROW] = '{5, 3, 4, 2, 6, 3, 2};
   localparam int         T_D    [NROW] = '{1, 2, 2, 4, 1, 16, 128};

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   task automatic wait_irq(input int limit, output int n, output int early);
      n = 0;
      early = 0;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (irq) break;
      end
      if (!irq) n = -1;
   endtask

   initial begin
      logic [31:0] v;
      int n, e;
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(2'd0, v); chk("R10 entry reset", v, 32'h0001_0000);
      rd(2'd1, v); chk("R10 start reset", v, 0);
      rd(2'd2, v); chk("R10/R4 left reset", v, 0);
      rd(2'd3, v); chk("R10 div reset", v, 0);
      chk("R10 irq low", {31'd0, irq}, 0);

      // Table walk: R1 divisor decode, R2 expiry timing, R9 vector
      for (int i = 0; i < NROW; i++) begin
         wr(2'd3, {28'd0, T_CONF[i]});
         rd(2'd3, v); chk("R1 div readback", v, {28'd0, T_CONF[i]});
         wr(2'd0, 32'h20 + i);
         wr(2'd1, T_N[i]);
         rd(2'd2, v); chk("R3 left after start", v, T_N[i]);
         wait_irq(T_N[i] * T_D[i] + 4, n, e);
         chk("R2/R1 expiry cycle", n, T_N[i] * T_D[i]);
         chk("R9 vector", {24'd0, irq_vector}, 32'h20 + i);
         rd(2'd2, v); chk("R4 left after one-shot", v, 0);
         @(negedge clk);
         chk("R9 single pulse", {31'd0, irq}, 0);
      end

      // R3 rounding up: D=4, N=5
      wr(2'd3, 32'h1);
      wr(2'd1, 5);
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R3 rounded up mid-group", v, 5);
      @(negedge clk);
      rd(2'd2, v); chk("R3 after one group", v, 4);
      wait_irq(40, n, e); chk("R3 remaining to expiry", n, 16);

      // R3 write to remaining count ignored
      wr(2'd3, 32'hB);
      wr(2'd1, 50);
      wr(2'd2, 7);
      rd(2'd2, v); chk("R3 left write ignored", v, 48);

      // R5 restart while running
      wr(2'd3, 32'h0);
      wr(2'd0, 32'h55);
      wr(2'd1, 10);
      repeat (5) @(negedge clk);
      wr(2'd1, 3);
      rd(2'd2, v); chk("R5 left after restart", v, 3);
      wait_irq(30, n, e); chk("R5 restart expiry", n, 6);
      chk("R5 vector", {24'd0, irq_vector}, 32'h55);

      // R6 read-only entry bits
      wr(2'd0, 32'h0001_50AA);
      rd(2'd0, v); chk("R6 ro bits ignored", v, 32'h0001_00AA);

      // R7 suppressed: counts, no request
      wr(2'd3, 32'hB);
      wr(2'd1, 4);
      repeat (2) @(negedge clk);
      rd(2'd2, v); chk("R7 counts while suppressed", v, 2);
      wait_irq(8, n, e); chk("R7 no request", n, -1);
      rd(2'd2, v); chk("R7 expired quietly", v, 0);

      // R8 repeat mode
      wr(2'd0, 32'h0002_0033);
      wr(2'd1, 3);
      for (int k = 0; k < 3; k++) begin
         wait_irq(10, n, e); chk("R8 repeat period", n, 3);
         chk("R8/R9 vector", {24'd0, irq_vector}, 32'h33);
      end
      wr(2'd1, 0);
      rd(2'd2, v); chk("R4 left after zero start", v, 0);
      wait_irq(10, n, e); chk("R4 stopped no request", n, -1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule